// File: doc/BRIEF.md
# Genlock Frame-Hold Controller

This block locks a local graphics frame generator to an incoming video stream, one whole frame at a time. The graphics timing is set up a few lines shorter than a video field, so every local frame ends a little before the matching video field does. When the local frame ends, the block drops the enable of the graphics pixel clock. That freezes the frame generator between frames. The block then waits for a rising edge on the external vertical sync, counts a programmable number of extra cycles, and raises the enable again.

If the video source stops, for example because its input clock has died, no sync edge comes and the graphics would freeze for good. An optional timeout, counted on the free-running system clock, releases the hold after a programmable number of cycles and sets a sticky flag. The flag is cleared with a one-cycle clear pulse. While lock is disabled, the clock enable stays high. The clock gating cell and the display timing generator are outside this block.

Top module: `genlock_hold_ctrl`

## Requirements
- R1: After reset `gfx_clk_en` is 1, `hold_busy` is 0 and `tmo_flag` is 0.
- R2: While `lock_en` is 0, `gfx_clk_en` stays 1 whatever `frame_end` does.
- R3: With `lock_en` at 1 and the clock running, a `frame_end` sampled at clock edge k drives `gfx_clk_en` to 0 and `hold_busy` to 1 from edge k on.
- R4: `vsync_in` passes through a two-flop synchronizer and only its rising edge counts. If `vsync_in` is first sampled high at edge k during a hold with `dly_cycles` = 0, `gfx_clk_en` is still 0 after edge k+1 and is 1 (with `hold_busy` 0) after edge k+2.
- R5: A non-zero `dly_cycles` value D pushes that release back by exactly D cycles, to edge k+2+D.
- R6: A sync edge that arrives while the clock is running is ignored and is not remembered. A `vsync_in` level that stays high gives no new edge and does not release a hold.
- R7: With `tmo_en` at 1 and `tmo_limit` L ≥ 1, a hold with no sync edge keeps `gfx_clk_en` at 0 for exactly L cycles. It then releases, and `tmo_flag` becomes 1 at the same edge.
- R8: With `tmo_en` at 0, a hold with no sync edge lasts for as long as no edge arrives.
- R9: `tmo_flag` stays set until a `tmo_clr` pulse sampled at an edge clears it at that edge. A timeout in the same cycle wins over the clear.
- R10: Dropping `lock_en` during a hold or a delay releases the clock at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_en | input | 1 | Enables frame locking |
| frame_end | input | 1 | One-cycle pulse when the local graphics frame ends |
| vsync_in | input | 1 | Asynchronous video vertical sync |
| dly_cycles | input | DLY_W | Extra cycles between the sync edge and the release |
| tmo_en | input | 1 | Enables the timeout |
| tmo_limit | input | TMO_W | Longest hold, in cycles, before a forced release |
| tmo_clr | input | 1 | Clear pulse for the sticky timeout flag |
| gfx_clk_en | output | 1 | Enable for the graphics pixel clock |
| hold_busy | output | 1 | High while the graphics clock is held |
| tmo_flag | output | 1 | Sticky flag, set when a timeout forced a release |

## Verification
The lock sequence is run with a zero delay and with a non-zero delay. Comparing the two shows that the synchronizer latency and the programmed delay add up, and rules out a release that is early or late by one cycle. Sync edges are also placed in the running state, and a sync level is held high across a whole hold. These cases separate true edge detection from level sensing, and show that no edge is stored before a hold starts. Holds with the timeout on and off, a flag clear, and lock being dropped in the middle of a hold cover the recovery paths.

// File: rtl/genlock_pkg.sv
package genlock_pkg;
  typedef enum logic [1:0] {
    GL_RUN   = 2'd0,
    GL_HOLD  = 2'd1,
    GL_DELAY = 2'd2
  } gl_state_e;
endpackage

// File: rtl/genlock_vsync_edge.sv
module genlock_vsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its history
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign rise_o = chain[STAGES-1] & ~chain[STAGES];

  // R4: an edge shows as a pulse one cycle wide
  p_rise_single_r4: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/genlock_delay_cnt.sv
module genlock_delay_cnt #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [DLY_W-1:0] value,
  input  logic             busy,
  output logic             last_o
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= value;
    else if (busy) cnt <= cnt - 1'b1;
  end

  assign last_o = (cnt <= DLY_W'(1));

  // R5: while the delay runs, cycles remain to be counted
  p_delay_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt != '0));
endmodule

// File: rtl/genlock_tmo_cnt.sv
module genlock_tmo_cnt #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             en,
  input  logic [TMO_W-1:0] limit,
  output logic             expired_o
);
  localparam int CW = TMO_W + 1;
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt <= '0;
    else if (~&cnt)     cnt <= cnt + 1'b1;
  end

  assign expired_o = en && ((CW'(cnt) + CW'(1)) >= CW'(limit));
endmodule

// File: rtl/genlock_hold_fsm.sv
module genlock_hold_fsm
  import genlock_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lock_en,
  input  logic      frame_end,
  input  logic      vs_rise,
  input  logic      dly_zero,
  input  logic      dly_last,
  input  logic      tmo_hit,
  input  logic      tmo_clr,
  output gl_state_e state_o,
  output logic      clk_en_o,
  output logic      tmo_flag_o
);
  gl_state_e state;
  logic      tmo_set;

  always_comb begin
    tmo_set = lock_en && (state == GL_HOLD) && !vs_rise && tmo_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= GL_RUN;
      clk_en_o <= 1'b1;
    end else if (!lock_en) begin
      state    <= GL_RUN;
      clk_en_o <= 1'b1;
    end else begin
      case (state)
        GL_RUN: if (frame_end) begin
          state    <= GL_HOLD;
          clk_en_o <= 1'b0;
        end
        GL_HOLD: if (vs_rise) begin
          if (dly_zero) begin
            state    <= GL_RUN;
            clk_en_o <= 1'b1;
          end else begin
            state <= GL_DELAY;
          end
        end else if (tmo_hit) begin
          state    <= GL_RUN;
          clk_en_o <= 1'b1;
        end
        GL_DELAY: if (dly_last) begin
          state    <= GL_RUN;
          clk_en_o <= 1'b1;
        end
        default: begin
          state    <= GL_RUN;
          clk_en_o <= 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          tmo_flag_o <= 1'b0;
    else if (tmo_set) tmo_flag_o <= 1'b1;
    else if (tmo_clr) tmo_flag_o <= 1'b0;
  end

  assign state_o = state;

  // R2: with lock off the clock keeps running
  p_free_run_r2: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> clk_en_o);
  // R3: end of frame while running starts a hold
  p_hold_on_end_r3: assert property (@(posedge clk) disable iff (rst)
    (lock_en && frame_end && clk_en_o) |=> !clk_en_o);
  // R9: the flag only drops on a clear
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (tmo_flag_o && !tmo_clr) |=> tmo_flag_o);
  // R6: no release from hold without an edge, a timeout or lock off
  p_hold_needs_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (state == GL_HOLD && lock_en && !vs_rise && !tmo_hit) |=> !clk_en_o);
endmodule

// File: rtl/genlock_hold_ctrl.sv
module genlock_hold_ctrl
  import genlock_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int TMO_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_en,
  input  logic             frame_end,
  input  logic             vsync_in,
  input  logic [DLY_W-1:0] dly_cycles,
  input  logic             tmo_en,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic             tmo_clr,
  output logic             gfx_clk_en,
  output logic             hold_busy,
  output logic             tmo_flag
);
  gl_state_e state;
  logic      vs_rise, dly_last, tmo_hit, dly_zero, dly_load;

  assign dly_zero = (dly_cycles == '0);
  assign dly_load = lock_en && (state == GL_HOLD) && vs_rise && !dly_zero;

  genlock_vsync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(vsync_in), .rise_o(vs_rise)
  );

  genlock_delay_cnt #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .load(dly_load), .value(dly_cycles),
    .busy(state == GL_DELAY), .last_o(dly_last)
  );

  genlock_tmo_cnt #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .clear(state != GL_HOLD), .en(tmo_en),
    .limit(tmo_limit), .expired_o(tmo_hit)
  );

  genlock_hold_fsm u_fsm (
    .clk(clk), .rst(rst), .lock_en(lock_en), .frame_end(frame_end),
    .vs_rise(vs_rise), .dly_zero(dly_zero), .dly_last(dly_last),
    .tmo_hit(tmo_hit), .tmo_clr(tmo_clr), .state_o(state),
    .clk_en_o(gfx_clk_en), .tmo_flag_o(tmo_flag)
  );

  assign hold_busy = !gfx_clk_en;

  // R10: lock off releases on the next edge
  p_lock_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (!lock_en && hold_busy) |=> !hold_busy);
endmodule

// File: tb/genlock_hold_ctrl_test.sv
module genlock_hold_ctrl_test;
  localparam int DLY_W = 8;
  localparam int TMO_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_en = 1'b0, frame_end = 1'b0, vsync_in = 1'b0;
  logic [DLY_W-1:0] dly_cycles = '0;
  logic tmo_en = 1'b0, tmo_clr = 1'b0;
  logic [TMO_W-1:0] tmo_limit = '0;
  logic gfx_clk_en, hold_busy, tmo_flag;

  genlock_hold_ctrl #(.DLY_W(DLY_W), .TMO_W(TMO_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .lock_en(lock_en), .frame_end(frame_end),
    .vsync_in(vsync_in), .dly_cycles(dly_cycles), .tmo_en(tmo_en),
    .tmo_limit(tmo_limit), .tmo_clr(tmo_clr), .gfx_clk_en(gfx_clk_en),
    .hold_busy(hold_busy), .tmo_flag(tmo_flag)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    int    cyc;
    int    sig;   // 0 clk_en, 1 hold_busy, 2 tmo_flag
    bit    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;
  exp_t it;
  logic act;

  always @(posedge clk) cyc++;

  // monitor: compare scoreboard entries due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      it = q.pop_front();
      act = (it.sig == 0) ? gfx_clk_en : (it.sig == 1) ? hold_busy : tmo_flag;
      checks++;
      if (it.cyc < cyc || act !== it.val) begin
        failures++;
        $display("FAIL %s sig=%0d cyc=%0d actual=%b expected=%b",
                 it.tag, it.sig, it.cyc, act, it.val);
      end
    end
  end

  task automatic expect_at(input int c, input int s, input bit v, input string tag);
    exp_t e;
    e.cyc = c; e.sig = s; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    tick(1);
  endtask

  task automatic end_frame();
    frame_end = 1'b1;
    tick(1);
    frame_end = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    tick(3);
    rst = 1'b0;
    n = cyc;
    // R1: reset state
    expect_at(n + 1, 0, 1'b1, "R1");
    expect_at(n + 1, 1, 1'b0, "R1");
    expect_at(n + 1, 2, 1'b0, "R1");
    drain();

    // R2: lock disabled, frame end has no effect
    n = cyc;
    end_frame();
    expect_at(n + 1, 0, 1'b1, "R2");
    expect_at(n + 4, 0, 1'b1, "R2");
    drain();

    // R3 + R4: lock with zero delay
    lock_en = 1'b1;
    tick(1);
    n = cyc;
    expect_at(n + 1, 0, 1'b0, "R3");
    expect_at(n + 1, 1, 1'b1, "R3");
    end_frame();
    tick(5);
    n = cyc;
    vsync_in = 1'b1;
    expect_at(n + 2, 0, 1'b0, "R4");
    expect_at(n + 3, 0, 1'b1, "R4");
    expect_at(n + 3, 1, 1'b0, "R4");
    tick(6);
    vsync_in = 1'b0;
    drain();

    // R5: delay of 7
    dly_cycles = 8'd7;
    end_frame();
    tick(4);
    n = cyc;
    vsync_in = 1'b1;
    expect_at(n + 2 + 7, 0, 1'b0, "R5");
    expect_at(n + 3 + 7, 0, 1'b1, "R5");
    tick(4);
    vsync_in = 1'b0;
    drain();
    dly_cycles = '0;

    // R6: edge while running is ignored; held level does not release
    vsync_in = 1'b1;
    tick(6);
    n = cyc;
    end_frame();
    expect_at(n + 20, 0, 1'b0, "R6");
    expect_at(n + 20, 1, 1'b1, "R6");
    drain();
    vsync_in = 1'b0;
    tick(4);
    n = cyc;
    vsync_in = 1'b1;
    expect_at(n + 3, 0, 1'b1, "R6");
    tick(4);
    vsync_in = 1'b0;
    drain();

    // R7: timeout after 10 cycles
    tmo_en = 1'b1;
    tmo_limit = 16'd10;
    n = cyc;
    end_frame();
    expect_at(n + 10, 0, 1'b0, "R7");
    expect_at(n + 10, 2, 1'b0, "R7");
    expect_at(n + 11, 0, 1'b1, "R7");
    expect_at(n + 11, 2, 1'b1, "R7");
    expect_at(n + 30, 2, 1'b1, "R9");
    drain();

    // R9: clear pulse
    n = cyc;
    tmo_clr = 1'b1;
    expect_at(n + 1, 2, 1'b0, "R9");
    tick(1);
    tmo_clr = 1'b0;
    drain();

    // R8: timeout disabled, hold persists
    tmo_en = 1'b0;
    n = cyc;
    end_frame();
    expect_at(n + 60, 0, 1'b0, "R8");
    expect_at(n + 60, 2, 1'b0, "R8");
    drain();
    n = cyc;
    vsync_in = 1'b1;
    expect_at(n + 3, 0, 1'b1, "R8");
    tick(4);
    vsync_in = 1'b0;
    drain();

    // R10: dropping lock during a hold
    n = cyc;
    end_frame();
    expect_at(n + 1, 1, 1'b1, "R10");
    tick(5);
    n = cyc;
    lock_en = 1'b0;
    expect_at(n + 1, 0, 1'b1, "R10");
    expect_at(n + 1, 1, 1'b0, "R10");
    drain();

    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule